// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master for 10G PHYs. It sends IEEE 802.3 Clause 45 frames on a clock pin and a bidirectional data pin. Software uses a small 32-bit register window and only polls. It first programs the PHY port address and the device address in the control word. Writing the 16-bit register number to the address word then launches an address frame. A later write to the data word launches a write frame. Setting the read flag in the control word launches a read frame, and the sixteen bits returned by the PHY land in the data word.

Two busy indications track progress. An address frame sets a flag in the status word. A write or read frame sets a flag in the top bit of the data word. A read in which no PHY answers during the turnaround sets a read-error flag, and the data then reads as all ones from the pulled-up line. The management clock runs only while a frame is on the wire. Its speed comes from an eight-bit divider field in the status word.

Top module: `mdio45_master`

## Requirements
- R1: After reset the status, control, data and address words (word indices 12, 13, 14, 15) all read zero, MDC is low and the MDIO output enable is low. MDC and the enable stay low whenever no frame is active.
- R2: A write to word 15 stores bits 15:0 as the register number and launches an address frame (opcode 00) that carries that number. Status bit 0 reads 1 from the write until the frame ends.
- R3: A write to word 14 stores bits 15:0 and launches a write frame (opcode 01) that carries them. Data bit 31 reads 1 until the frame ends. Only one busy flag is set at a time.
- R4: A write to word 13 with bit 15 set launches a read frame. Its opcode is 11, or 10 when bit 14 of the same write is 1. The port address is taken from bits 9:5 and the device address from bits 4:0 of that write. The sixteen bits sampled from the PHY end up in data bits 15:0.
- R5: A frame is sent MSB first as 32 ones of preamble, then 00, then the 2-bit opcode, the 5-bit port address, the 5-bit device address, the turnaround 10 and 16 data bits. Control bit 10 set drops the preamble.
- R6: The status divider field is bits 15:8. Each MDC half period lasts divider+1 system clocks, and a frame of N bits keeps its busy flag set for 2·N·(divider+1) clocks.
- R7: In a read frame the enable is low for the last 18 bit times. If the second turnaround bit sampled is not 0, status bit 1 is set. It is cleared when the next read frame starts.
- R8: While either busy flag is set, every register write is ignored. No register changes and no extra frame is sent.
- R9: MDIO output and enable change only on MDC falling edges inside a frame. Input bits are sampled as MDC rises.
- R10: Control readback shows bits 14, 10, 9:5 and 4:0 as written, with bits 15 and 13:11 reading 0. Status bits 7:2 and 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word index for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for the data pin |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest conditions to reach from the ports are register writes that arrive while a frame is still shifting out, and the turnaround slot of a read frame. The turnaround slot decides between clean data and the error flag. The bench fires a burst of writes to every word in the cycles right after a write frame is launched. It then checks that neither registers nor the edge count on MDC moved. A PHY model on the pin counts released MDC edges and returns a chosen turnaround and data pattern, and it can be switched off so that the pulled-up line makes the read fail. Random frame kinds, dividers and preamble settings are mixed in around these directed cases.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

  // register word indices inside the window
  localparam int WORD_STAT = 12;
  localparam int WORD_CTL  = 13;
  localparam int WORD_DATA = 14;
  localparam int WORD_ADDR = 15;

  localparam int DIV_W        = 8;   // width of the clock divider field
  localparam int TAIL_W       = 32;  // ST + OP + PRT + DEV + TA + DATA
  localparam int RELEASE_BITS = 18;  // bits the PHY owns in a read frame

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RDINC = 2'b10,
    OP_READ  = 2'b11
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e    op;
    logic [4:0]  prt;
    logic [4:0]  dev;
    logic [15:0] payload;
    logic        no_pre;
  } frame_req_t;

  // frame body after the preamble, MSB goes on the wire first
  function automatic logic [TAIL_W-1:0] frame_tail(input frame_req_t r);
    return {2'b00, r.op, r.prt, r.dev, 2'b10, r.payload};
  endfunction

  // system clocks spent in one MDC half period
  function automatic int unsigned half_period(input logic [DIV_W-1:0] div);
    return int'(div) + 1;
  endfunction

endpackage

// File: rtl/mdio45_mdc_gen.sv
module mdio45_mdc_gen
  import mdio45_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio45_frame_engine.sv
module mdio45_frame_engine
  import mdio45_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  frame_req_t  req,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        done_read,
  output logic        rd_err,
  output logic [15:0] rd_data
);

  localparam int FRAME_W = PRE_LEN + TAIL_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx;
  logic               is_read;
  logic               released;
  logic               last_bit;
  logic               ta_slot;
  logic               data_slot;

  assign released  = is_read && (idx < IDX_W'(RELEASE_BITS));
  assign last_bit  = (idx == '0);
  assign ta_slot   = is_read && (idx == IDX_W'(RELEASE_BITS - 2));
  assign data_slot = is_read && (idx < IDX_W'(RELEASE_BITS - 2));

  assign done      = active && fall_tick && last_bit;
  assign done_read = done && is_read;
  assign mdio_o    = active ? frame[idx] : 1'b0;
  assign mdio_oe   = active && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      frame   <= '0;
      idx     <= '0;
      is_read <= 1'b0;
      rd_err  <= 1'b0;
      rd_data <= '0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        frame   <= {{PRE_LEN{1'b1}}, frame_tail(req)};
        idx     <= req.no_pre ? IDX_W'(TAIL_W - 1) : IDX_W'(FRAME_W - 1);
        is_read <= req.op[1];
        if (req.op[1]) begin
          rd_err  <= 1'b0;
          rd_data <= '0;
        end
      end
    end else begin
      if (rise_tick) begin
        if (ta_slot)   rd_err  <= mdio_i;
        if (data_slot) rd_data <= {rd_data[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_bit) active <= 1'b0;
        else          idx    <= idx - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio45_regs.sv
module mdio45_regs
  import mdio45_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_done,
  input  logic              frame_done_read,
  input  logic              rd_err,
  input  logic [15:0]       rd_data,
  output logic              cmd_start,
  output frame_req_t        cmd_req,
  output logic [DIV_W-1:0]  div,
  output logic              busy_addr,
  output logic              busy_data
);

  logic [4:0]  devad_q;
  logic [4:0]  prtad_q;
  logic        nopre_q;
  logic        postinc_q;
  logic [15:0] regnum_q;
  logic [15:0] data_q;

  logic hit_stat, hit_ctl, hit_data, hit_addr;
  logic wr_ok, cmd_addr, cmd_write, cmd_read;
  logic unused_wdata;

  assign hit_stat = (bus_addr == ADDR_W'(WORD_STAT));
  assign hit_ctl  = (bus_addr == ADDR_W'(WORD_CTL));
  assign hit_data = (bus_addr == ADDR_W'(WORD_DATA));
  assign hit_addr = (bus_addr == ADDR_W'(WORD_ADDR));

  assign wr_ok     = bus_wr && !(busy_addr || busy_data);
  assign cmd_addr  = wr_ok && hit_addr;
  assign cmd_write = wr_ok && hit_data;
  assign cmd_read  = wr_ok && hit_ctl && bus_wdata[15];
  assign cmd_start = cmd_addr || cmd_write || cmd_read;

  assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[13:11]};

  always_comb begin
    cmd_req.prt     = hit_ctl ? bus_wdata[9:5] : prtad_q;
    cmd_req.dev     = hit_ctl ? bus_wdata[4:0] : devad_q;
    cmd_req.no_pre  = hit_ctl ? bus_wdata[10]  : nopre_q;
    cmd_req.payload = hit_ctl ? 16'h0000 : bus_wdata[15:0];
    if (cmd_addr)       cmd_req.op = OP_ADDR;
    else if (cmd_write) cmd_req.op = OP_WRITE;
    else if (bus_wdata[14]) cmd_req.op = OP_RDINC;
    else                cmd_req.op = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div       <= '0;
      devad_q   <= '0;
      prtad_q   <= '0;
      nopre_q   <= 1'b0;
      postinc_q <= 1'b0;
      regnum_q  <= '0;
      data_q    <= '0;
      busy_addr <= 1'b0;
      busy_data <= 1'b0;
    end else begin
      if (frame_done) begin
        busy_addr <= 1'b0;
        busy_data <= 1'b0;
        if (frame_done_read) data_q <= rd_data;
      end
      if (wr_ok) begin
        if (hit_stat) div <= bus_wdata[15:8];
        if (hit_ctl) begin
          devad_q   <= bus_wdata[4:0];
          prtad_q   <= bus_wdata[9:5];
          nopre_q   <= bus_wdata[10];
          postinc_q <= bus_wdata[14];
          if (bus_wdata[15]) busy_data <= 1'b1;
        end
        if (hit_data) begin
          data_q    <= bus_wdata[15:0];
          busy_data <= 1'b1;
        end
        if (hit_addr) begin
          regnum_q  <= bus_wdata[15:0];
          busy_addr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (hit_stat)      bus_rdata = {16'h0, div, 6'h0, rd_err, busy_addr};
    else if (hit_ctl)  bus_rdata = {16'h0, 1'b0, postinc_q, 3'b000, nopre_q, prtad_q, devad_q};
    else if (hit_data) bus_rdata = {busy_data, 15'h0, data_q};
    else if (hit_addr) bus_rdata = {16'h0, regnum_q};
  end

endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  frame_req_t       cmd_req;
  logic             cmd_start;
  logic [DIV_W-1:0] div;
  logic             busy_addr;
  logic             busy_data;
  logic             eng_active;
  logic             mdc_rise;
  logic             mdc_fall;
  logic             frame_done;
  logic             frame_done_read;
  logic             rd_err;
  logic [15:0]      rd_data;

  mdio45_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .frame_done      (frame_done),
    .frame_done_read (frame_done_read),
    .rd_err          (rd_err),
    .rd_data         (rd_data),
    .cmd_start       (cmd_start),
    .cmd_req         (cmd_req),
    .div             (div),
    .busy_addr       (busy_addr),
    .busy_data       (busy_data)
  );

  mdio45_mdc_gen u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_active),
    .div       (div),
    .mdc       (mdc),
    .rise_tick (mdc_rise),
    .fall_tick (mdc_fall)
  );

  mdio45_frame_engine #(.PRE_LEN(PRE_LEN)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cmd_start),
    .req       (cmd_req),
    .rise_tick (mdc_rise),
    .fall_tick (mdc_fall),
    .mdio_i    (mdio_i),
    .active    (eng_active),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (frame_done),
    .done_read (frame_done_read),
    .rd_err    (rd_err),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/mdio45_master_checker.sv
module mdio45_master_checker (
  input logic clk,
  input logic rst_n,
  input logic busy_addr,
  input logic busy_data,
  input logic eng_active,
  input logic cmd_start,
  input logic mdc_rise,
  input logic mdc_fall,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> (!mdc && !mdio_oe)); // R1

  AST_BUSY_TRACKS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_addr || busy_data) == eng_active); // R2

  AST_SINGLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_addr && busy_data)); // R3

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> !cmd_start); // R8

  AST_RISE_TICK_RAISES_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_rise |=> mdc); // R6

  AST_FALL_TICK_LOWERS_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_fall |=> !mdc); // R6

  AST_PIN_HOLDS_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_active && $past(eng_active) && !$past(mdc_fall))
      |-> ($stable(mdio_o) && $stable(mdio_oe))); // R9

endmodule

bind mdio45_master mdio45_master_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_addr  (busy_addr),
  .busy_data  (busy_data),
  .eng_active (eng_active),
  .cmd_start  (cmd_start),
  .mdc_rise   (mdc_rise),
  .mdc_fall   (mdc_fall),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio45_master_bench.sv
module mdio45_master_bench;
  import mdio45_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  always #4 clk = ~clk;

  mdio45_master u_mdio45_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // PHY-side monitor and responder
  logic [63:0] cap = 64'h0;
  logic [63:0] oeh = 64'h0;
  int          nrise = 0;
  int          relcnt = 0;
  int          rel_base = 0;
  logic        phy_on = 1'b1;
  logic [17:0] resp = 18'h3FFFF;
  logic [17:0] shv;

  always @(posedge mdc) begin
    cap   <= {cap[62:0], mdio_o};
    oeh   <= {oeh[62:0], mdio_oe};
    nrise <= nrise + 1;
    if (!mdio_oe) relcnt <= relcnt + 1;
  end

  always_comb begin
    shv    = resp << (relcnt - rel_base);
    mdio_i = 1'b1;
    if (phy_on && (relcnt - rel_base) < 18) mdio_i = shv[17];
  end

  localparam logic [3:0] A_STAT = 4'(WORD_STAT);
  localparam logic [3:0] A_CTL  = 4'(WORD_CTL);
  localparam logic [3:0] A_DATA = 4'(WORD_DATA);
  localparam logic [3:0] A_ADDR = 4'(WORD_ADDR);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input logic [3:0] a, input int bitpos, output int cyc);
    logic [31:0] d;
    cyc = 0;
    rd(a, d);
    while ((d & (32'h1 << bitpos)) != 0 && cyc < 100000) begin
      cyc++;
      @(negedge clk);
      rd(a, d);
    end
  endtask

  // expected wire image of a full-length frame, LSB is the last bit sent
  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                             input logic [4:0] dv, input logic [15:0] pay);
    logic [63:0] v;
    v = {64{1'b1}};
    v[31:30] = 2'b00;
    v[29:28] = op;
    v[27:23] = p;
    v[22:18] = dv;
    v[17:16] = 2'b10;
    v[15:0]  = pay;
    return v;
  endfunction

  logic [15:0] last_addr = 16'h0;

  // kind: 0 address frame, 1 write frame, 2 read frame
  task automatic run_cmd(input int kind, input logic [7:0] dv, input bit nopre, input bit pinc,
                         input logic [4:0] p, input logic [4:0] de, input logic [15:0] val,
                         input bit phy);
    int          cyc, nbits, base_rise;
    logic [1:0]  op;
    logic [63:0] ef, mask, oexp;
    logic [31:0] d;
    logic [31:0] ctlw;
    ctlw = {16'h0, 1'b0, pinc, 3'b000, nopre, p, de};
    wr(A_STAT, {16'h0, dv, 8'h00});
    wr(A_CTL, ctlw);
    base_rise = nrise;
    rel_base  = relcnt;
    phy_on    = phy;
    resp      = {2'b10, val};
    nbits     = nopre ? 32 : 64;
    if (kind == 0) begin
      op = 2'b00; wr(A_ADDR, {16'h0, val}); last_addr = val;
      wait_idle(A_STAT, 0, cyc);
    end else if (kind == 1) begin
      op = 2'b01; wr(A_DATA, {16'h0, val});
      wait_idle(A_DATA, 31, cyc);
    end else begin
      op = pinc ? 2'b10 : 2'b11; wr(A_CTL, ctlw | 32'h8000);
      wait_idle(A_DATA, 31, cyc);
    end
    @(negedge clk);
    chk(cyc == 2 * nbits * (int'(dv) + 1), "R6 busy duration",
        64'(cyc), 64'(2 * nbits * (int'(dv) + 1)));
    chk(nrise - base_rise == nbits, "R5 MDC rising edges per frame",
        64'(nrise - base_rise), 64'(nbits));
    ef   = exp_frame(op, p, de, (kind == 2) ? 16'h0 : val);
    mask = nopre ? 64'h0000_0000_FFFF_FFFF : {64{1'b1}};
    oexp = mask;
    if (kind == 2) begin
      mask = mask & ~64'h3FFFF;
      oexp = oexp & ~64'h3FFFF;
    end
    chk(((cap ^ ef) & mask) == 64'h0, (kind == 2) ? "R4 read frame bits (R9 rise sampling)"
        : (kind == 1) ? "R3 write frame bits (R5 layout)" : "R2 address frame bits (R5 layout)",
        cap & mask, ef & mask);
    chk((oeh & (nopre ? 64'h0000_0000_FFFF_FFFF : {64{1'b1}})) == oexp, "R7 output enable pattern",
        oeh, oexp);
    if (kind == 0) begin
      rd(A_ADDR, d);
      chk(d == {16'h0, val}, "R2 address word readback", 64'(d), 64'({16'h0, val}));
    end else if (kind == 1) begin
      rd(A_DATA, d);
      chk(d == {16'h0, val}, "R3 data word after write frame", 64'(d), 64'({16'h0, val}));
    end else begin
      rd(A_DATA, d);
      chk(d[15:0] == (phy ? val : 16'hFFFF), "R4 read data captured",
          64'(d[15:0]), 64'(phy ? val : 16'hFFFF));
      rd(A_STAT, d);
      chk(d[1] == !phy, "R7 read error flag", 64'(d[1]), 64'(!phy));
    end
  endtask

  initial begin
    #(8 * 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int          cyc, r0;
    void'($urandom(32'd4517));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d); chk(d == 32'h0, "R1 status after reset", 64'(d), 64'h0);
    rd(A_CTL, d);  chk(d == 32'h0, "R1 control after reset", 64'(d), 64'h0);
    rd(A_DATA, d); chk(d == 32'h0, "R1 data after reset", 64'(d), 64'h0);
    rd(A_ADDR, d); chk(d == 32'h0, "R1 address after reset", 64'(d), 64'h0);
    chk(!mdc && !mdio_oe, "R1 pins idle after reset", 64'({mdc, mdio_oe}), 64'h0);

    // R10 readback layout
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk(d == 32'h0000_FF00, "R10 status readback", 64'(d), 64'h0000_FF00);
    wr(A_CTL, 32'hFFFF_7FFF);
    rd(A_CTL, d);  chk(d == 32'h0000_47FF, "R10 control readback", 64'(d), 64'h0000_47FF);

    // directed corners
    run_cmd(0, 8'd0, 1'b0, 1'b0, 5'h15, 5'h0A, 16'hC3A5, 1'b1);
    run_cmd(1, 8'd1, 1'b1, 1'b0, 5'h1F, 5'h01, 16'h8001, 1'b1);
    run_cmd(2, 8'd0, 1'b0, 1'b1, 5'h03, 5'h1E, 16'h5A0F, 1'b1); // R4 post-increment opcode
    run_cmd(2, 8'd2, 1'b0, 1'b0, 5'h0C, 5'h07, 16'h1234, 1'b0); // R7 absent PHY
    run_cmd(2, 8'd0, 1'b1, 1'b0, 5'h0C, 5'h07, 16'hFEDC, 1'b1); // R7 flag clears

    // R8 writes during a frame are dropped
    wr(A_STAT, 32'h0000_0100);
    wr(A_CTL, 32'h0000_00A5);
    r0 = nrise;
    wr(A_DATA, 32'h0000_A5A5);
    wr(A_DATA, 32'h0000_1234);
    wr(A_ADDR, 32'h0000_BEEF);
    wr(A_CTL, 32'h0000_C7FF);
    wr(A_STAT, 32'h0000_0700);
    wait_idle(A_DATA, 31, cyc);
    rd(A_DATA, d); chk(d == 32'h0000_A5A5, "R8 data kept", 64'(d), 64'h0000_A5A5);
    rd(A_ADDR, d); chk(d == {16'h0, last_addr}, "R8 address kept", 64'(d), 64'({16'h0, last_addr}));
    rd(A_CTL, d);  chk(d == 32'h0000_00A5, "R8 control kept", 64'(d), 64'h0000_00A5);
    rd(A_STAT, d); chk(d[15:8] == 8'h01, "R8 divider kept", 64'(d[15:8]), 64'h01);
    chk(nrise - r0 == 64, "R8 single frame", 64'(nrise - r0), 64'd64);
    repeat (300) @(negedge clk);
    chk(nrise - r0 == 64, "R8 no deferred frame", 64'(nrise - r0), 64'd64);

    // constrained random mix
    for (int i = 0; i < 20; i++) begin
      int kind;
      kind = int'($urandom % 3);
      run_cmd(kind, 8'($urandom % 4), 1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
              16'($urandom), ($urandom % 4) != 0);
    end

    chk(!mdc && !mdio_oe, "R1 pins idle at end", 64'({mdc, mdio_oe}), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule